// File: doc/BRIEF.md
# Hysteresis-Aware Perturbation Learning Sequencer

This controller trains a small analog feed-forward network. In that network, each synapse weight comes from the conductance of a hysteretic device. The conductance is set by the height of a write pulse. The sequencer keeps one signed millivolt write amplitude per device and one flag per device that records which hysteresis branch the device sits on (rising or falling). The network has N_IN inputs plus a bias, N_HID hidden neurons plus a bias, and one output. Each synapse uses an excitatory device and an inhibitory device, so the default network has 26 devices.

For every device the sequencer works through the same steps:
- It asks an external evaluator for the summed squared error.
- It writes a probe pulse that is dV further out along the device's branch, then asks for the error again.
- If the error did not grow, it keeps a gradient-style update. This is the non-inverting path.
- If the error grew, it sends a reset pulse whose level depends on the sign of the stored amplitude. It then moves the amplitude by the fixed offset between the two branch centres and flips the branch flag. This is the inverting path.

After each full pass the sequencer requests one more error value and compares it with a limit. Training stops when the error is at or below the limit, or when MAX_PASS passes have run.

The evaluator, the pulse drivers and the network are outside the block. Every request uses a level handshake: `meas_req` is answered by `meas_valid`, and `pulse_req` is answered by `pulse_ack`. Control lives in one FSM:
- IDLE and STOP both go to MEAS1 on `start`.
- MEAS1 goes to PROBE on a valid measurement.
- PROBE goes to MEAS2 on ack.
- MEAS2 goes to DECIDE on a valid measurement.
- DECIDE goes to RESET if the error grew, otherwise to WRITE.
- RESET goes to WRITE on ack.
- WRITE goes to ADV on ack, and the new amplitude is stored at that point.
- ADV goes to CHECK after the last device, otherwise to MEAS1.
- CHECK goes to STOP when the error is at or below the limit or the pass limit is reached. Otherwise it goes back to MEAS1 for device 0.

Top module: `hyst_learn_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `meas_req` and `pulse_req` are low and `pass_count` is 0. Every stored amplitude is 0 mV, and every branch flag is rising (flag value 0).
- R2: Devices are visited in index order 0 to NDEV-1 in every pass. Index 2s is the excitatory device of synapse s and index 2s+1 is its inhibitory device, so the excitatory device always comes first. Synapses 0 to N_HID are the output-layer synapses, so the output layer is handled before the hidden layer.
- R3: For each device the sequencer does three things in order: it measures E1, it writes a probe pulse, and it measures E2. The probe amplitude is A+dV on a rising branch and A-dV on a falling branch. A is the stored amplitude and dV is 10 mV. The probe is clamped to the allowed range.
- R4: When E2 <= E1, no reset pulse is issued. The new amplitude is A+S on a rising branch and A-S on a falling branch, where S = floor((E1-E2)*eta / (dV*2^ETA_FRAC)). ETA_FRAC is 4. S is capped at 5000, and the result is clamped. The branch flag is unchanged.
- R5: When E2 > E1, a reset pulse (`pulse_kind`=1) is issued first. Its level is -2000 mV if A >= 0 and +3000 mV if A < 0. A write pulse (`pulse_kind`=0) follows with amplitude A-2900 on a rising branch or A+2900 on a falling branch, clamped. The branch flag then toggles.
- R6: Every write pulse amplitude lies within -2000 mV to +3000 mV.
- R7: After the last device of a pass, one extra error value is requested. If it is at or below `err_limit`, `done` rises, `fail` stays low, `busy` falls, and `pass_count` equals the number of passes completed.
- R8: If MAX_PASS passes complete without meeting the limit, `done` and `fail` are both high and `pass_count` equals MAX_PASS.
- R9: A pending request keeps its device, amplitude and kind stable until it is accepted. A pulse request and a measurement request are never high at the same time.
- R10: `start` clears `done`, `fail` and `pass_count`. It keeps the learned amplitudes and branch flags, so the next run continues from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training run (accepted in IDLE or STOP) |
| eta | input | ETA_W | Learning rate, unsigned with ETA_FRAC fraction bits |
| err_limit | input | ERR_W | Pass error threshold |
| meas_req | output | 1 | Error measurement request |
| meas_valid | input | 1 | Evaluator returns `meas_err` |
| meas_err | input | ERR_W | Summed squared error over the patterns |
| pulse_req | output | 1 | Pulse request to the analog front end |
| pulse_ack | input | 1 | Pulse applied |
| pulse_dev | output | IDX_W | Target device index |
| pulse_mv | output | AMP_W | Signed pulse amplitude in mV |
| pulse_kind | output | 1 | 0 = write pulse, 1 = reset pulse |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training ended |
| fail | output | 1 | Ended on the pass limit |
| pass_count | output | PASS_W | Passes whose error check has been made |

## Verification
The bench runs every device of five passes. It cycles the error pairs through five shapes:
- a moderate decrease, which gives a scaled step;
- equal errors, which gives a zero step and must not trigger a reset;
- a rise of one unit, which forces the inverting path;
- a huge decrease, which drives the step into the cap and the range clamp;
- a one-unit decrease, which gives a step that truncates to zero.

Because the shape for each device shifts from pass to pass, devices move between branches and amplitudes reach both range limits. The probes and reset levels are then tried from both signs and both branch flags. The two runs use different learning rates. The end-of-pass errors sit exactly at the limit and one above it, which separates a finished run, a run that continues, and a run that ends on the pass limit. Acceptance of each pulse is held off for a varying number of cycles to check that pending requests stay stable.

// File: rtl/hls_pkg.sv
package hls_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MEAS1,
        ST_PROBE,
        ST_MEAS2,
        ST_DECIDE,
        ST_RESET,
        ST_WRITE,
        ST_ADV,
        ST_CHECK,
        ST_STOP
    } seq_state_e;

    typedef enum logic {
        PK_WRITE = 1'b0,
        PK_RESET = 1'b1
    } pulse_kind_e;

    typedef enum logic {
        BR_RISE = 1'b0,
        BR_FALL = 1'b1
    } branch_e;

    function automatic int clamp_mv(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/hls_amp_file.sv
module hls_amp_file
    import hls_pkg::*;
#(
    parameter int NDEV  = 26,
    parameter int AMP_W = 16,
    parameter int IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic signed [AMP_W-1:0] rd_amp,
    output branch_e                 rd_br,
    input  logic                    we,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic signed [AMP_W-1:0] wr_amp,
    input  branch_e                 wr_br
);

    logic signed [AMP_W-1:0] amp_q [NDEV];
    branch_e                 br_q  [NDEV];

    // Storage: one amplitude and one branch flag per device
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NDEV; i++) begin
                amp_q[i] <= '0;
                br_q[i]  <= BR_RISE;
            end
        end else if (we) begin
            for (int i = 0; i < NDEV; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    amp_q[i] <= wr_amp;
                    br_q[i]  <= wr_br;
                end
            end
        end
    end

    // Read port
    always_comb begin
        rd_amp = '0;
        rd_br  = BR_RISE;
        for (int i = 0; i < NDEV; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_amp = amp_q[i];
                rd_br  = br_q[i];
            end
        end
    end

    // R2: writes only ever target an existing device
    a_r2_write_index: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(wr_idx) < NDEV));

endmodule

// File: rtl/hls_step_calc.sv
module hls_step_calc
    import hls_pkg::*;
#(
    parameter int AMP_W      = 16,
    parameter int ERR_W      = 20,
    parameter int ETA_W      = 8,
    parameter int ETA_FRAC   = 4,
    parameter int DV_MV      = 10,
    parameter int OFFSET_MV  = 2900,
    parameter int POS_MAX_MV = 3000,
    parameter int NEG_MIN_MV = -2000,
    parameter int RST_POS_MV = 3000,
    parameter int RST_NEG_MV = -2000
) (
    input  logic signed [AMP_W-1:0] amp_old,
    input  branch_e                 br_old,
    input  logic [ERR_W-1:0]        e_before,
    input  logic [ERR_W-1:0]        e_after,
    input  logic [ETA_W-1:0]        eta,
    output logic signed [AMP_W-1:0] probe_mv,
    output logic signed [AMP_W-1:0] next_mv,
    output branch_e                 next_br,
    output logic signed [AMP_W-1:0] reset_mv,
    output logic                    worse
);

    localparam int PW       = ERR_W + ETA_W + 1;
    localparam int STEP_CAP = POS_MAX_MV - NEG_MIN_MV;

    logic [ERR_W-1:0] gain;
    logic [PW-1:0]    prod;
    logic [PW-1:0]    quo;
    logic [PW-1:0]    step_raw;
    int               step_i;
    int               old_i;
    int               probe_i;
    int               raw_i;

    always_comb begin
        worse    = (e_after > e_before);
        gain     = e_before - e_after;
        prod     = PW'(gain) * PW'(eta);
        quo      = prod / PW'(DV_MV);
        step_raw = quo >> ETA_FRAC;
        step_i   = (step_raw > PW'(STEP_CAP)) ? STEP_CAP : int'(step_raw);
        old_i    = int'(amp_old);

        // Probe one step further along the current branch
        probe_i  = (br_old == BR_RISE) ? old_i + DV_MV : old_i - DV_MV;
        probe_mv = AMP_W'(clamp_mv(probe_i, NEG_MIN_MV, POS_MAX_MV));

        if (worse) begin
            // Jump to the same conductance on the other branch
            raw_i   = (br_old == BR_RISE) ? old_i - OFFSET_MV : old_i + OFFSET_MV;
            next_br = (br_old == BR_RISE) ? BR_FALL : BR_RISE;
        end else begin
            raw_i   = (br_old == BR_RISE) ? old_i + step_i : old_i - step_i;
            next_br = br_old;
        end
        next_mv  = AMP_W'(clamp_mv(raw_i, NEG_MIN_MV, POS_MAX_MV));
        reset_mv = (old_i >= 0) ? AMP_W'(RST_NEG_MV) : AMP_W'(RST_POS_MV);
    end

endmodule

// File: rtl/hls_walk_cnt.sv
module hls_walk_cnt #(
    parameter int NDEV     = 26,
    parameter int MAX_PASS = 2000,
    parameter int IDX_W    = 5,
    parameter int PASS_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              dev_step,
    input  logic              pass_step,
    output logic [IDX_W-1:0]  dev_idx,
    output logic              dev_last,
    output logic [PASS_W-1:0] pass_cnt,
    output logic              pass_final
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_idx  <= '0;
            pass_cnt <= '0;
        end else if (clr) begin
            dev_idx  <= '0;
            pass_cnt <= '0;
        end else begin
            if (dev_step) dev_idx <= dev_last ? '0 : dev_idx + 1'b1;
            if (pass_step) pass_cnt <= pass_cnt + 1'b1;
        end
    end

    assign dev_last   = (dev_idx == IDX_W'(NDEV - 1));
    assign pass_final = (pass_cnt == PASS_W'(MAX_PASS - 1));

    // R8: the pass counter never runs past its limit
    a_r8_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pass_cnt) <= MAX_PASS);

    // R2: device index stays inside the network
    a_r2_dev_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dev_idx) < NDEV);

endmodule

// File: rtl/hyst_learn_seq.sv
module hyst_learn_seq
    import hls_pkg::*;
#(
    parameter int N_IN       = 2,
    parameter int N_HID      = 3,
    parameter int AMP_W      = 16,
    parameter int ERR_W      = 20,
    parameter int ETA_W      = 8,
    parameter int ETA_FRAC   = 4,
    parameter int DV_MV      = 10,
    parameter int OFFSET_MV  = 2900,
    parameter int POS_MAX_MV = 3000,
    parameter int NEG_MIN_MV = -2000,
    parameter int RST_POS_MV = 3000,
    parameter int RST_NEG_MV = -2000,
    parameter int MAX_PASS   = 2000,
    localparam int N_SYN     = (N_IN + 1) * N_HID + (N_HID + 1),
    localparam int NDEV      = 2 * N_SYN,
    localparam int IDX_W     = $clog2(NDEV),
    localparam int PASS_W    = $clog2(MAX_PASS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ETA_W-1:0]        eta,
    input  logic [ERR_W-1:0]        err_limit,
    output logic                    meas_req,
    input  logic                    meas_valid,
    input  logic [ERR_W-1:0]        meas_err,
    output logic                    pulse_req,
    input  logic                    pulse_ack,
    output logic [IDX_W-1:0]        pulse_dev,
    output logic signed [AMP_W-1:0] pulse_mv,
    output logic                    pulse_kind,
    output logic                    busy,
    output logic                    done,
    output logic                    fail,
    output logic [PASS_W-1:0]       pass_count
);

    seq_state_e state, state_nx;

    logic [ERR_W-1:0]        e1_q, e2_q;
    logic signed [AMP_W-1:0] nxt_mv_q, rst_mv_q;
    branch_e                 nxt_br_q;
    logic                    done_q, fail_q;

    logic [IDX_W-1:0]        dev_idx;
    logic                    dev_last, pass_final;
    logic [PASS_W-1:0]       pass_cnt;

    logic signed [AMP_W-1:0] cur_amp, calc_probe, calc_next, calc_rst;
    branch_e                 cur_br, calc_br;
    logic                    calc_worse;

    logic                    run_go, file_we, dev_step, pass_step;

    assign run_go    = ((state == ST_IDLE) || (state == ST_STOP)) && start;
    assign file_we   = (state == ST_WRITE) && pulse_ack;
    assign dev_step  = (state == ST_ADV);
    assign pass_step = (state == ST_CHECK) && meas_valid;

    hls_walk_cnt #(
        .NDEV(NDEV), .MAX_PASS(MAX_PASS), .IDX_W(IDX_W), .PASS_W(PASS_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(run_go), .dev_step(dev_step),
        .pass_step(pass_step), .dev_idx(dev_idx), .dev_last(dev_last),
        .pass_cnt(pass_cnt), .pass_final(pass_final)
    );

    hls_amp_file #(
        .NDEV(NDEV), .AMP_W(AMP_W), .IDX_W(IDX_W)
    ) u_amps (
        .clk(clk), .rst_n(rst_n), .rd_idx(dev_idx), .rd_amp(cur_amp),
        .rd_br(cur_br), .we(file_we), .wr_idx(dev_idx), .wr_amp(nxt_mv_q),
        .wr_br(nxt_br_q)
    );

    hls_step_calc #(
        .AMP_W(AMP_W), .ERR_W(ERR_W), .ETA_W(ETA_W), .ETA_FRAC(ETA_FRAC),
        .DV_MV(DV_MV), .OFFSET_MV(OFFSET_MV), .POS_MAX_MV(POS_MAX_MV),
        .NEG_MIN_MV(NEG_MIN_MV), .RST_POS_MV(RST_POS_MV), .RST_NEG_MV(RST_NEG_MV)
    ) u_calc (
        .amp_old(cur_amp), .br_old(cur_br), .e_before(e1_q), .e_after(e2_q),
        .eta(eta), .probe_mv(calc_probe), .next_mv(calc_next),
        .next_br(calc_br), .reset_mv(calc_rst), .worse(calc_worse)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_STOP: if (start) state_nx = ST_MEAS1;
            ST_MEAS1:  if (meas_valid) state_nx = ST_PROBE;
            ST_PROBE:  if (pulse_ack)  state_nx = ST_MEAS2;
            ST_MEAS2:  if (meas_valid) state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = calc_worse ? ST_RESET : ST_WRITE;
            ST_RESET:  if (pulse_ack)  state_nx = ST_WRITE;
            ST_WRITE:  if (pulse_ack)  state_nx = ST_ADV;
            ST_ADV:    state_nx = dev_last ? ST_CHECK : ST_MEAS1;
            ST_CHECK: begin
                if (meas_valid) begin
                    if (meas_err <= err_limit || pass_final) state_nx = ST_STOP;
                    else                                     state_nx = ST_MEAS1;
                end
            end
        endcase
    end

    // Datapath registers: measured errors, decided amplitude, run result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e1_q     <= '0;
            e2_q     <= '0;
            nxt_mv_q <= '0;
            rst_mv_q <= '0;
            nxt_br_q <= BR_RISE;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            if (run_go) begin
                done_q <= 1'b0;
                fail_q <= 1'b0;
            end
            if (state == ST_MEAS1 && meas_valid) e1_q <= meas_err;
            if (state == ST_MEAS2 && meas_valid) e2_q <= meas_err;
            if (state == ST_DECIDE) begin
                nxt_mv_q <= calc_next;
                nxt_br_q <= calc_br;
                rst_mv_q <= calc_rst;
            end
            if (pass_step) begin
                if (meas_err <= err_limit) begin
                    done_q <= 1'b1;
                    fail_q <= 1'b0;
                end else if (pass_final) begin
                    done_q <= 1'b1;
                    fail_q <= 1'b1;
                end
            end
        end
    end

    // Moore outputs
    always_comb begin
        meas_req   = 1'b0;
        pulse_req  = 1'b0;
        pulse_kind = PK_WRITE;
        pulse_mv   = nxt_mv_q;
        unique case (state)
            ST_MEAS1, ST_MEAS2, ST_CHECK: meas_req = 1'b1;
            ST_PROBE: begin
                pulse_req = 1'b1;
                pulse_mv  = calc_probe;
            end
            ST_RESET: begin
                pulse_req  = 1'b1;
                pulse_kind = PK_RESET;
                pulse_mv   = rst_mv_q;
            end
            ST_WRITE: pulse_req = 1'b1;
            ST_IDLE, ST_DECIDE, ST_ADV, ST_STOP: ;
        endcase
    end

    assign pulse_dev  = dev_idx;
    assign busy       = (state != ST_IDLE) && (state != ST_STOP);
    assign done       = done_q;
    assign fail       = fail_q;
    assign pass_count = pass_cnt;

    // R6: every write amplitude stays inside the device window
    a_r6_write_range: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_req && pulse_kind == PK_WRITE) |->
            (int'(pulse_mv) >= NEG_MIN_MV && int'(pulse_mv) <= POS_MAX_MV));

    // R5: reset pulses only carry one of the two reset levels
    a_r5_reset_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_req && pulse_kind == PK_RESET) |->
            (int'(pulse_mv) == RST_NEG_MV || int'(pulse_mv) == RST_POS_MV));

    // R9: never two requests at once
    a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_req && pulse_req));

    // R9: a pending pulse request holds its fields
    a_r9_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_req && !pulse_ack) |=>
            (pulse_req && $stable(pulse_mv) && $stable(pulse_dev) && $stable(pulse_kind)));

    // R9: a pending measurement request stays up until answered
    a_r9_meas_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && !meas_valid) |=> meas_req);

    // R7: a finished run is quiet
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !meas_req && !pulse_req));

    // R8: fail is only reported together with done
    a_r8_fail_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

endmodule

// File: tb/hyst_learn_seq_test.sv
module hyst_learn_seq_test;

    localparam int NDEV   = 26;
    localparam int MAXP   = 3;
    localparam int PASS_W = $clog2(MAXP + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  eta = 8'd16;
    logic [19:0] err_limit = 20'd1000;
    logic        meas_req;
    logic        meas_valid = 1'b0;
    logic [19:0] meas_err = '0;
    logic        pulse_req;
    logic        pulse_ack = 1'b0;
    logic [4:0]  pulse_dev;
    logic signed [15:0] pulse_mv;
    logic        pulse_kind;
    logic        busy, done, fail;
    logic [PASS_W-1:0] pass_count;

    hyst_learn_seq #(.MAX_PASS(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .eta(eta), .err_limit(err_limit),
        .meas_req(meas_req), .meas_valid(meas_valid), .meas_err(meas_err),
        .pulse_req(pulse_req), .pulse_ack(pulse_ack), .pulse_dev(pulse_dev),
        .pulse_mv(pulse_mv), .pulse_kind(pulse_kind), .busy(busy), .done(done),
        .fail(fail), .pass_count(pass_count)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int amp_m [NDEV];
    int br_m  [NDEV];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        if (v < -2000) return -2000;
        if (v > 3000) return 3000;
        return v;
    endfunction

    task automatic wait_for(input bit want_meas, output bit got);
        got = 1'b0;
        for (int t = 0; t < 500; t++) begin
            if (want_meas ? meas_req : pulse_req) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic give_meas(input int err, input string req);
        bit got;
        wait_for(1'b1, got);
        chk(got, {req, " measurement request"}, int'(got), 1);
        chk(!pulse_req, "R9 exclusive requests", int'(pulse_req), 0);
        meas_err   = 20'(err);
        meas_valid = 1'b1;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic take_pulse(input int dev, input int mv, input int kind,
                              input int hold, input string req);
        bit got;
        wait_for(1'b0, got);
        chk(got, {req, " pulse request"}, int'(got), 1);
        chk(int'(pulse_dev) == dev, "R2 device order", int'(pulse_dev), dev);
        chk(int'(pulse_mv) == mv, {req, " amplitude"}, int'(pulse_mv), mv);
        chk(int'(pulse_kind) == kind, {req, " kind"}, int'(pulse_kind), kind);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(pulse_req && int'(pulse_mv) == mv, "R9 hold", int'(pulse_mv), mv);
        end
        pulse_ack = 1'b1;
        @(negedge clk);
        pulse_ack = 1'b0;
    endtask

    task automatic run_device(input int d, input int sel, input int eta_v);
        int e1, e2, probe, nv, step;
        case (sel)
            0: begin e1 = 5000;   e2 = 3400; end
            1: begin e1 = 7000;   e2 = 7000; end
            2: begin e1 = 4000;   e2 = 4001; end
            3: begin e1 = 900000; e2 = 0;    end
            default: begin e1 = 3000; e2 = 2999; end
        endcase
        give_meas(e1, "R3");
        probe = clampv(br_m[d] == 0 ? amp_m[d] + 10 : amp_m[d] - 10);
        take_pulse(d, probe, 0, d % 3, "R3 probe");
        give_meas(e2, "R3");
        if (e2 > e1) begin
            take_pulse(d, amp_m[d] >= 0 ? -2000 : 3000, 1, (d + 1) % 3, "R5 reset");
            nv = clampv(br_m[d] == 0 ? amp_m[d] - 2900 : amp_m[d] + 2900);
            take_pulse(d, nv, 0, 0, "R5 jump write");
            br_m[d] = 1 - br_m[d];
        end else begin
            step = ((e1 - e2) * eta_v) / 160;
            if (step > 5000) step = 5000;
            nv = clampv(br_m[d] == 0 ? amp_m[d] + step : amp_m[d] - step);
            take_pulse(d, nv, 0, (d + 2) % 3, "R4 update write");
        end
        chk(nv >= -2000 && nv <= 3000, "R6 range", nv, 0);
        amp_m[d] = nv;
    endtask

    task automatic run_pass(input int p, input int eta_v, input int final_err);
        for (int d = 0; d < NDEV; d++) run_device(d, (d + 3 * p) % 5, eta_v);
        give_meas(final_err, "R7");
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        for (int i = 0; i < NDEV; i++) begin
            amp_m[i] = 0;
            br_m[i]  = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !fail, "R1 status after reset", int'({busy, done, fail}), 0);
        chk(!meas_req && !pulse_req, "R1 no requests", int'({meas_req, pulse_req}), 0);
        chk(pass_count == '0, "R1 pass count", int'(pass_count), 0);

        // Run 1: converges on the second pass (error equal to the limit)
        eta = 8'd16;
        pulse_start();
        chk(busy, "R1 busy after start", int'(busy), 1);
        run_pass(0, 16, 5000);
        chk(!done && busy, "R7 continue above limit", int'(done), 0);
        run_pass(1, 16, 1000);
        chk(done && !fail, "R7 done on limit", int'({done, fail}), 2);
        chk(!busy, "R7 idle when done", int'(busy), 0);
        chk(int'(pass_count) == 2, "R7 pass count", int'(pass_count), 2);
        repeat (3) @(negedge clk);
        chk(!meas_req && !pulse_req, "R7 quiet after done", int'({meas_req, pulse_req}), 0);

        // Run 2: never meets the limit, ends on the pass limit; amplitudes carry over (R10)
        eta = 8'd40;
        pulse_start();
        chk(!done && !fail, "R10 flags cleared by start", int'({done, fail}), 0);
        chk(pass_count == '0, "R10 pass count cleared", int'(pass_count), 0);
        for (int p = 2; p < 2 + MAXP; p++) begin
            run_pass(p, 40, 1001);
            if (p < 1 + MAXP) chk(!done, "R8 not yet at limit", int'(done), 0);
        end
        chk(done && fail, "R8 fail at pass limit", int'({done, fail}), 3);
        chk(int'(pass_count) == MAXP, "R8 final pass count", int'(pass_count), MAXP);
        chk(!busy, "R8 idle after fail", int'(busy), 0);
        summary();
    end

endmodule